// File: doc/BRIEF.md
# Chainable FIFO Slice with Token-Passed Depth Expansion

This block is one slice of a first-in first-out buffer that can be linked in a ring with identical slices to build a deeper buffer. Every slice sees the same write strobe, write data and read strobe. A write token and a read token travel around the ring. Only the slice holding the write token stores incoming words. Only the slice holding the read token puts its oldest word on its data output; every other slice drives zeros there, so the outputs of all slices can be ORed into one shared bus.

A slice hands a token on when it stores into, or pops from, its last location. It does this by pulling the matching expansion output low for that one cycle. The next slice in the ring takes the token at the same clock edge, so the following strobe is served without a gap. The slice whose first-load input is held low owns both tokens after reset. Each slice reports its own active-low full and empty flags. Outside logic merges them: the chain is full, or empty, only when every slice says so.

Top module: `dxfifo_slice`

## Requirements
- R1: While reset is low and after it is released with no strobes, empty_n is 0, full_n is 1, both expansion outputs are 1, and rd_oe is 1 exactly on the slice whose first_n is 0 (0 on slices with first_n at 1).
- R2: A write is stored only when the slice holds the write token and full_n is 1. A write strobe while full, or on a slice without the write token, changes no stored word and no flag.
- R3: A slice holding the read token drives rd_oe at 1 and its oldest stored word on rd_data. A slice without it drives rd_oe at 0 and rd_data at all zeros.
- R4: Across a ring of slices, words leave the ORed bus in the order they were accepted.
- R5: xo_wr_n is 0 in exactly the cycle in which an accepted write targets location DEPTH-1, combinationally in that cycle. It is 1 in the next cycle, and the slice then no longer holds the write token.
- R6: xo_rd_n is 0 in exactly the cycle in which an accepted read pops location DEPTH-1. It is 1 in the next cycle, and rd_oe goes to 0 at that edge unless xi_rd_n is also 0.
- R7: An xi_wr_n or xi_rd_n level of 0 at a clock edge gives the slice that token from that edge, so the strobe in the very next cycle is served by this slice.
- R8: full_n is 0 exactly when the slice holds DEPTH words, and empty_n is 0 exactly when it holds none. The two are never 0 together.
- R9: A read strobe while the slice is empty, or on a slice without the read token, pops nothing: the flags and the word shown do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| first_n | input | 1 | Low marks the slice owning both tokens after reset |
| xi_wr_n | input | 1 | Active-low write-token pulse from the previous slice |
| xi_rd_n | input | 1 | Active-low read-token pulse from the previous slice |
| wr_en | input | 1 | Write strobe, shared by all slices |
| wr_data | input | WIDTH | Write data, shared by all slices |
| rd_en | input | 1 | Read strobe, shared by all slices |
| rd_data | output | WIDTH | Oldest word while holding the read token, else zero |
| rd_oe | output | 1 | High while this slice holds the read token |
| full_n | output | 1 | Low when the slice holds DEPTH words |
| empty_n | output | 1 | Low when the slice holds no words |
| xo_wr_n | output | 1 | Active-low write-token pulse to the next slice |
| xo_rd_n | output | 1 | Active-low read-token pulse to the next slice |

## Verification
A lost or duplicated token shows up on the very next cycle. The one-hot pattern of rd_oe across the ring breaks, or the ORed bus shows a wrong or merged word where the model expects the head of its queue. A pointer that wraps at the wrong place moves the expansion pulse to a different cycle than the one predicted from the global write or read position. It also breaks data order on the first pass around the ring. A miscounted fill level shows up as a merged full or empty flag disagreeing with the model's occupancy in the cycle after the strobe that caused it.

// File: rtl/dxfifo_slice.sv
module dxfifo_slice #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_n,
  input  logic             xi_wr_n,
  input  logic             xi_rd_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe,
  output logic             full_n,
  output logic             empty_n,
  output logic             xo_wr_n,
  output logic             xo_rd_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             wtok, rtok;

  wire wr_go   = wtok & wr_en & (cnt != FULLCNT);
  wire rd_go   = rtok & rd_en & (cnt != '0);
  wire wr_last = (wptr == LAST);
  wire rd_last = (rptr == LAST);

  assign xo_wr_n = ~(wr_go & wr_last);
  assign xo_rd_n = ~(rd_go & rd_last);
  assign full_n  = (cnt != FULLCNT);
  assign empty_n = (cnt != '0);
  assign rd_oe   = rtok;
  assign rd_data = rtok ? mem[rptr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      wtok <= ~first_n;
      rtok <= ~first_n;
    end else begin
      if (wr_go) wptr <= wr_last ? '0 : wptr + 1'b1;
      if (rd_go) rptr <= rd_last ? '0 : rptr + 1'b1;
      if (wr_go && !rd_go)      cnt <= cnt + 1'b1;
      else if (rd_go && !wr_go) cnt <= cnt - 1'b1;
      wtok <= (wtok & xo_wr_n) | ~xi_wr_n;
      rtok <= (rtok & xo_rd_n) | ~xi_rd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[wptr] <= wr_data;
  end
endmodule

// File: rtl/dxfifo_slice_chk.sv
module dxfifo_slice_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic rd_en,
  input logic rd_oe,
  input logic full_n,
  input logic empty_n,
  input logic xi_rd_n,
  input logic xo_wr_n,
  input logic xo_rd_n
);
  AST_XO_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) !xo_wr_n |=> xo_wr_n); // R5
  AST_XO_WR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !xo_wr_n |-> wr_en); // R5
  AST_XO_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) !xo_rd_n |=> xo_rd_n); // R6
  AST_RD_PASS_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (!xo_rd_n && xi_rd_n) |=> !rd_oe); // R6
  AST_RD_TOKEN_GAIN: assert property (@(posedge clk) disable iff (!rst_n) !xi_rd_n |=> rd_oe); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(!empty_n && !full_n)); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!full_n && !(rd_en && rd_oe)) |=> !full_n); // R2
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!empty_n && !wr_en) |=> !empty_n); // R9
endmodule

bind dxfifo_slice dxfifo_slice_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_oe(rd_oe),
  .full_n(full_n), .empty_n(empty_n), .xi_rd_n(xi_rd_n),
  .xo_wr_n(xo_wr_n), .xo_rd_n(xo_rd_n)
);

// File: tb/dxfifo_slice_tb_top.sv
`timescale 1ns/1ps
module dxfifo_slice_tb_top;
  localparam int W = 9;
  localparam int D = 4;
  localparam int N = 3;
  localparam int CAP = D * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rdd [N];
  logic [N-1:0] oe, fn, en, xw, xr;
  int checks = 0, fails = 0;
  int q[$];
  int wpos = 0, rpos = 0;

  always #2 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_sl
    if (i == 0) begin : g_first
      dxfifo_slice #(.WIDTH(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .first_n(1'b0),
        .xi_wr_n(xw[N-1]), .xi_rd_n(xr[N-1]),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rdd[i]), .rd_oe(oe[i]), .full_n(fn[i]), .empty_n(en[i]),
        .xo_wr_n(xw[i]), .xo_rd_n(xr[i]));
    end else begin : g_other
      dxfifo_slice #(.WIDTH(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .first_n(1'b1),
        .xi_wr_n(xw[i-1]), .xi_rd_n(xr[i-1]),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rdd[i]), .rd_oe(oe[i]), .full_n(fn[i]), .empty_n(en[i]),
        .xo_wr_n(xw[i]), .xo_rd_n(xr[i]));
    end
  end

  wire [W-1:0] bus = rdd[0] | rdd[1] | rdd[2];
  wire all_full  = ~|fn;
  wire all_empty = ~|en;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] owner(input int pos);
    return N'(1) << (pos / D);
  endfunction

  function automatic logic [N-1:0] pulse(input bit acc, input int pos);
    return (acc && (pos % D == D - 1)) ? ~owner(pos) : '1;
  endfunction

  // compare at negedge against the model, then advance the model for the next edge
  task automatic step(input bit we, input bit re, input logic [W-1:0] d);
    bit ef, ff, wacc, racc;
    @(posedge clk); #1;
    wr_en = we; rd_en = re; wr_data = d;
    @(negedge clk);
    ef = (q.size() == 0);
    ff = (q.size() == CAP);
    wacc = we && !ff;
    racc = re && !ef;
    chk(all_empty == ef, "R8 merged empty", int'(all_empty), int'(ef));
    chk(all_full == ff, "R8 merged full", int'(all_full), int'(ff));
    chk(oe == owner(rpos), "R3/R7 read owner", int'(oe), int'(owner(rpos)));
    if (!ef) chk(bus == W'(q[0]), "R4 head word", int'(bus), q[0]);
    chk(xw == pulse(wacc, wpos), "R5 write pulse", int'(xw), int'(pulse(wacc, wpos)));
    chk(xr == pulse(racc, rpos), "R6 read pulse", int'(xr), int'(pulse(racc, rpos)));
    if (racc) begin void'(q.pop_front()); rpos = (rpos + 1) % CAP; end
    if (wacc) begin q.push_back(int'(d)); wpos = (wpos + 1) % CAP; end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(en == '0 && fn == '1, "R1 flags in reset", int'({en, fn}), int'({3'b000, 3'b111}));
    chk(xw == '1 && xr == '1, "R1 expansion idle", int'({xw, xr}), 63);
    chk(oe == 3'b001, "R1 token on first slice", int'(oe), 1);
    chk(bus == '0 || oe == 3'b001, "R3 bus quiet", int'(bus), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(oe == 3'b001 && en == '0, "R1 after release", int'({oe, en}), 8);
    chk(rdd[1] == '0 && rdd[2] == '0, "R3 non-owners drive zero", int'(rdd[1] | rdd[2]), 0);

    // R9: read on empty chain pops nothing
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b1, '0);
    step(1'b1, 1'b0, 9'h055);
    step(1'b0, 1'b0, '0);
    chk(bus == 9'h055, "R9 word survives empty reads", int'(bus), 'h55);
    // fill to capacity, then R2: writes while full are dropped
    for (int k = 0; k < CAP; k++) step(1'b1, 1'b0, W'(k + 9'h100));
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 9'h1ff);
    chk(all_full, "R2 still full after extra writes", int'(all_full), 1);
    // drain completely; each head is checked against the model
    for (int k = 0; k < CAP + 3; k++) step(1'b0, 1'b1, '0);
    chk(all_empty && q.size() == 0, "R2 no dropped word reappears", int'(all_empty), 1);
    // R7: back-to-back writes across every hand-over
    for (int k = 0; k < 2 * CAP; k++) step(1'b1, 1'b1, W'(k * 7 + 3));
    // random phases with varying bias toward filling or draining
    for (int ph = 0; ph < 12; ph++) begin
      int wb = (ph % 3 == 0) ? 85 : (ph % 3 == 1) ? 20 : 50;
      for (int k = 0; k < 300; k++)
        step(($urandom % 100) < wb, ($urandom % 100) < (100 - wb), W'($urandom));
    end
    for (int k = 0; k < CAP + 2; k++) step(1'b0, 1'b1, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule